// File: doc/BRIEF.md
# Field-Programmable Logic Array

This block is a small logic array that is configured at run time to compute a set of combinational functions. It takes N input signals. Each input is split into a true literal and an inverted literal. A programmable AND plane builds P product terms. Each term may use any mix of literals, so a term need not be a full minterm. A programmable OR plane then merges a chosen subset of those terms into each of the M outputs. Finally, a per-output polarity bit decides whether the output carries the sum as it is or its inverse.

Configuration is written one product-term row per clock through a synchronous port. A row carries three things: the literal links for that term, the output links for that term, and a polarity vector for all outputs. An erase command returns the whole array to its blank state, and reset does the same. The path from inputs to outputs contains no registers. Only the stored links are clocked.

Top module: `fpla_core`

## Requirements
- R1: After reset every link is intact: all literal fields are 11, all output links are 1, and polarity is 0. As a result, out_vec is 0 for every input value.
- R2: The literal field of input i sits at cfg_and_row bits [2i+1:2i]. Bit 2i connects the true literal and bit 2i+1 connects the inverted literal. The codes are 01 for true, 10 for inverted and 00 for no connection. A term is the AND of its connected literals, so terms are not limited to minterms.
- R3: A term whose literal field is all 00 evaluates to 1. A term with code 11 on any input evaluates to 0.
- R4: Output j is the OR of every term whose row has bit j of cfg_or_row set. An output with no term linked gives 0 before the polarity stage.
- R5: Bit j of cfg_pol set to 1 inverts output j, and set to 0 passes the sum unchanged. Each accepted row write replaces the whole polarity vector.
- R6: A row write is accepted at the rising edge where cfg_we is high, into the row given by cfg_addr. Outputs keep the old function until that edge and show the new function right after it.
- R7: cfg_erase restores the blank state of R1 at the next rising edge, and it wins over a row write made in the same cycle.
- R8: A write with cfg_addr of P or more changes nothing. This includes the polarity vector.
- R9: out_vec follows a change of in_vec within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset to the blank state |
| cfg_we | input | 1 | Row write strobe |
| cfg_erase | input | 1 | Erase-to-blank command |
| cfg_addr | input | clog2(P) | Row (product term) index |
| cfg_and_row | input | 2N | Literal link fields of the row |
| cfg_or_row | input | M | Output links of the row |
| cfg_pol | input | M | Polarity vector, 1 = inverted output |
| in_vec | input | N | Function inputs |
| out_vec | output | M | Function outputs |

## Verification
The case that is hardest to reach from the ports is a term that can never be observed directly. Examples are a term killed by a code 11 field, or an always-true empty term that sits behind an output with no links. Such terms only show up through their effect on an output's OR. The bench programs dedicated rows for these cases, then relinks or unlinks them one at a time, sweeping all input values after each change. Further sweeps after many arithmetically generated configurations cover every code in every field position. Writes to the two unused addresses, and an erase that collides with a write, are also driven, and each is followed by a full sweep.

// File: rtl/fpla_pkg.sv
`timescale 1ns/1ps
package fpla_pkg;
   localparam logic [1:0] LINK_NONE = 2'b00;
   localparam logic [1:0] LINK_TRUE = 2'b01;
   localparam logic [1:0] LINK_COMP = 2'b10;
   localparam logic [1:0] LINK_BOTH = 2'b11;

   // A literal pair lets a term through unless a connected literal is low.
   function automatic logic lit_pass(input logic [1:0] link, input logic t_lit, input logic c_lit);
      return !((link[0] && !t_lit) || (link[1] && !c_lit));
   endfunction
endpackage

// File: rtl/fpla_cfg_store.sv
`timescale 1ns/1ps
module fpla_cfg_store #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 6,
   parameter int N_OUT  = 3,
   parameter int AW     = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic                               erase,
   input  logic [AW-1:0]                      addr,
   input  logic [2*N_IN-1:0]                  and_row,
   input  logic [N_OUT-1:0]                   or_row,
   input  logic [N_OUT-1:0]                   pol,
   output logic [N_TERM-1:0][2*N_IN-1:0]      and_links,
   output logic [N_TERM-1:0][N_OUT-1:0]       or_links,
   output logic [N_OUT-1:0]                   pol_q
);
   localparam logic [AW:0] ROW_LIMIT = (AW+1)'(N_TERM);

   logic addr_ok;
   assign addr_ok = {1'b0, addr} < ROW_LIMIT;

   always_ff @(posedge clk) begin
      if (!rst_n || erase) begin
         and_links <= '1;
         or_links  <= '1;
         pol_q     <= '0;
      end else if (we && addr_ok) begin
         and_links[addr] <= and_row;
         or_links[addr]  <= or_row;
         pol_q           <= pol;
      end
   end
endmodule

// File: rtl/fpla_and_plane.sv
`timescale 1ns/1ps
module fpla_and_plane
   import fpla_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int N_TERM = 6
) (
   input  logic [N_IN-1:0]                    in_vec,
   input  logic [N_TERM-1:0][2*N_IN-1:0]      and_links,
   output logic [N_TERM-1:0]                  term_vec
);
   logic [N_IN-1:0] lit_t;
   logic [N_IN-1:0] lit_c;

   for (genvar i = 0; i < N_IN; i++) begin : g_buf
      assign lit_t[i] = in_vec[i];
      assign lit_c[i] = ~in_vec[i];
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      always_comb begin
         logic acc;
         acc = 1'b1;
         for (int i = 0; i < N_IN; i++) begin
            acc = acc & lit_pass(and_links[t][2*i +: 2], lit_t[i], lit_c[i]);
         end
         term_vec[t] = acc;
      end
   end
endmodule

// File: rtl/fpla_or_plane.sv
`timescale 1ns/1ps
module fpla_or_plane #(
   parameter int N_TERM = 6,
   parameter int N_OUT  = 3
) (
   input  logic [N_TERM-1:0]                  term_vec,
   input  logic [N_TERM-1:0][N_OUT-1:0]       or_links,
   input  logic [N_OUT-1:0]                   pol_q,
   output logic [N_OUT-1:0]                   out_vec
);
   for (genvar j = 0; j < N_OUT; j++) begin : g_out
      logic [N_TERM-1:0] column;
      logic              sum;
      for (genvar t = 0; t < N_TERM; t++) begin : g_col
         assign column[t] = or_links[t][j] & term_vec[t];
      end
      assign sum        = |column;
      assign out_vec[j] = sum ^ pol_q[j];
   end
endmodule

// File: rtl/fpla_core.sv
`timescale 1ns/1ps
module fpla_core #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 6,
   parameter int N_OUT  = 3,
   localparam int AW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_erase,
   input  logic [AW-1:0]       cfg_addr,
   input  logic [2*N_IN-1:0]   cfg_and_row,
   input  logic [N_OUT-1:0]    cfg_or_row,
   input  logic [N_OUT-1:0]    cfg_pol,
   input  logic [N_IN-1:0]     in_vec,
   output logic [N_OUT-1:0]    out_vec
);
   if (N_IN < 1 || N_IN > 32) begin : g_bad_in
      $error("fpla_core: N_IN must be 1..32");
   end
   if (N_TERM < 1 || N_TERM > 256) begin : g_bad_term
      $error("fpla_core: N_TERM must be 1..256");
   end
   if (N_OUT < 1 || N_OUT > 64) begin : g_bad_out
      $error("fpla_core: N_OUT must be 1..64");
   end

   logic [N_TERM-1:0][2*N_IN-1:0] and_links;
   logic [N_TERM-1:0][N_OUT-1:0]  or_links;
   logic [N_OUT-1:0]              pol_q;
   logic [N_TERM-1:0]             term_vec;

   fpla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .erase     (cfg_erase),
      .addr      (cfg_addr),
      .and_row   (cfg_and_row),
      .or_row    (cfg_or_row),
      .pol       (cfg_pol),
      .and_links (and_links),
      .or_links  (or_links),
      .pol_q     (pol_q)
   );

   fpla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .in_vec    (in_vec),
      .and_links (and_links),
      .term_vec  (term_vec)
   );

   fpla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
      .term_vec  (term_vec),
      .or_links  (or_links),
      .pol_q     (pol_q),
      .out_vec   (out_vec)
   );
endmodule

// File: rtl/fpla_core_chk.sv
`timescale 1ns/1ps
module fpla_core_chk #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 6,
   parameter int N_OUT  = 3,
   parameter int AW     = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           cfg_we,
   input logic                           cfg_erase,
   input logic [AW-1:0]                  cfg_addr,
   input logic [2*N_IN-1:0]              cfg_and_row,
   input logic [N_OUT-1:0]               cfg_or_row,
   input logic [N_OUT-1:0]               cfg_pol,
   input logic [N_IN-1:0]                in_vec,
   input logic [N_OUT-1:0]               out_vec,
   input logic [N_TERM-1:0][2*N_IN-1:0]  and_links,
   input logic [N_TERM-1:0][N_OUT-1:0]   or_links,
   input logic [N_OUT-1:0]               pol_q
);
   localparam logic [AW:0] ROW_LIMIT = (AW+1)'(N_TERM);

   logic addr_in_range;
   assign addr_in_range = {1'b0, cfg_addr} < ROW_LIMIT;

   // R7: one cycle after an erase the array is blank and every output reads 0
   a_r7_erase_blank: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_erase) |-> (out_vec == '0 && and_links == '1 && pol_q == '0));

   // R6: an accepted write lands in the addressed row
   a_r6_row_written: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && !$past(cfg_erase) && $past(addr_in_range)) |->
      (and_links[$past(cfg_addr)] == $past(cfg_and_row) &&
       or_links[$past(cfg_addr)] == $past(cfg_or_row) && pol_q == $past(cfg_pol)));

   // R8: a write beyond the last row leaves all stored links alone
   a_r8_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && !$past(cfg_erase) && !$past(addr_in_range)) |->
      ($stable(and_links) && $stable(or_links) && $stable(pol_q)));

   // R9: no config change and no input change means no output change
   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && !$past(cfg_erase) && $stable(in_vec)) |-> $stable(out_vec));

   for (genvar j = 0; j < N_OUT; j++) begin : g_chk_out
      logic [N_TERM-1:0] col;
      for (genvar t = 0; t < N_TERM; t++) begin : g_col
         assign col[t] = or_links[t][j];
         // R3: an empty term linked to output j forces its sum high
         a_r3_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
            (and_links[t] == '0 && or_links[t][j]) |-> (out_vec[j] == !pol_q[j]));
      end
      // R4: an output with no linked term shows only its polarity bit
      a_r4_empty_column: assert property (@(posedge clk) disable iff (!rst_n)
         (col == '0) |-> (out_vec[j] == pol_q[j]));
   end
endmodule

bind fpla_core fpla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_erase   (cfg_erase),
   .cfg_addr    (cfg_addr),
   .cfg_and_row (cfg_and_row),
   .cfg_or_row  (cfg_or_row),
   .cfg_pol     (cfg_pol),
   .in_vec      (in_vec),
   .out_vec     (out_vec),
   .and_links   (and_links),
   .or_links    (or_links),
   .pol_q       (pol_q)
);

// File: tb/tb_fpla_core.sv
`timescale 1ns/1ps
module tb_fpla_core;
   localparam int N  = 4;
   localparam int P  = 6;
   localparam int M  = 3;
   localparam int AW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic           cfg_erase = 1'b0;
   logic [AW-1:0]  cfg_addr = '0;
   logic [2*N-1:0] cfg_and_row = '0;
   logic [M-1:0]   cfg_or_row = '0;
   logic [M-1:0]   cfg_pol = '0;
   logic [N-1:0]   in_vec = '0;
   logic [M-1:0]   out_vec;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   logic [2*N-1:0] m_and [P];
   logic [M-1:0]   m_or  [P];
   logic [M-1:0]   m_pol;

   always #2.5 clk = ~clk;

   fpla_core #(.N_IN(N), .N_TERM(P), .N_OUT(M)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
      .cfg_addr(cfg_addr), .cfg_and_row(cfg_and_row), .cfg_or_row(cfg_or_row),
      .cfg_pol(cfg_pol), .in_vec(in_vec), .out_vec(out_vec)
   );

   function automatic logic [M-1:0] model(input logic [N-1:0] x);
      logic [M-1:0] r;
      for (int j = 0; j < M; j++) begin
         logic s;
         s = 1'b0;
         for (int t = 0; t < P; t++) begin
            if (m_or[t][j]) begin
               logic p;
               p = 1'b1;
               for (int i = 0; i < N; i++) begin
                  if (m_and[t][2*i] && !x[i]) p = 1'b0;
                  if (m_and[t][2*i+1] && x[i]) p = 1'b0;
               end
               s = s | p;
            end
         end
         r[j] = s ^ m_pol[j];
      end
      return r;
   endfunction

   task automatic model_blank();
      for (int t = 0; t < P; t++) begin
         m_and[t] = '1;
         m_or[t]  = '1;
      end
      m_pol = '0;
   endtask

   task automatic check(input logic [M-1:0] act, input logic [M-1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: in=%b got %b expected %b", tag, in_vec, act, exp);
      end
   endtask

   task automatic sweep(input string tag);
      for (int v = 0; v < (1 << N); v++) begin
         @(negedge clk);
         in_vec = v[N-1:0];
         #1 check(out_vec, model(in_vec), tag);
      end
   endtask

   task automatic write_row(input int a, input logic [2*N-1:0] ar,
                            input logic [M-1:0] orr, input logic [M-1:0] pl);
      @(negedge clk);
      cfg_addr = a[AW-1:0]; cfg_and_row = ar; cfg_or_row = orr; cfg_pol = pl;
      cfg_we = 1'b1;
      // R6: nothing changes before the edge
      #1 check(out_vec, model(in_vec), "R6 before edge");
      @(posedge clk);
      #1 cfg_we = 1'b0;
      if (a < P) begin
         m_and[a] = ar; m_or[a] = orr; m_pol = pl;
      end
      // R6: new function visible right after the edge
      check(out_vec, model(in_vec), "R6 after edge");
   endtask

   task automatic erase_dev(input bit with_write);
      @(negedge clk);
      cfg_erase = 1'b1;
      if (with_write) begin
         cfg_we = 1'b1; cfg_addr = '0; cfg_and_row = '0; cfg_or_row = '1; cfg_pol = '1;
      end
      @(posedge clk);
      #1 cfg_erase = 1'b0; cfg_we = 1'b0;
      model_blank();
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      model_blank();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      sweep("R1 reset blank");

      // Fixed program: non-minterm, empty, killed and full-minterm terms
      write_row(0, 8'b0000_0101, 3'b001, 3'b000);   // R2 x0 & x1
      write_row(1, 8'b0110_0000, 3'b011, 3'b000);   // R2 ~x2 & x3
      write_row(2, 8'b0000_0000, 3'b100, 3'b000);   // R3 empty term -> 1
      write_row(3, 8'b0000_0011, 3'b010, 3'b000);   // R3 code 11 -> 0
      write_row(4, 8'b1001_1001, 3'b010, 3'b000);   // R2 x0 ~x1 x2 ~x3
      write_row(5, 8'b0000_0000, 3'b000, 3'b000);
      sweep("R2 R3 R4 fixed program");

      write_row(5, 8'b0000_0000, 3'b000, 3'b101);
      sweep("R5 polarity");
      write_row(2, 8'b0000_0000, 3'b000, 3'b101);
      sweep("R4 output without terms");
      write_row(2, 8'b0000_0000, 3'b000, 3'b000);
      sweep("R4 output without terms true polarity");

      write_row(6, 8'b1111_1111, 3'b111, 3'b111);
      write_row(7, 8'b0000_0000, 3'b111, 3'b111);
      sweep("R8 out of range write");

      // R9: inputs change mid-cycle, output follows before next edge
      @(posedge clk);
      #0.5 in_vec = 4'b0011;
      #0.5 check(out_vec, model(in_vec), "R9 mid-cycle");
      in_vec = 4'b1000;
      #0.5 check(out_vec, model(in_vec), "R9 mid-cycle");

      erase_dev(1'b0);
      sweep("R7 erase");
      write_row(1, 8'b0000_0000, 3'b111, 3'b010);
      erase_dev(1'b1);
      sweep("R7 erase beats write");

      lf = 16'hACE1;
      for (int k = 0; k < 24; k++) begin
         for (int r = 0; r < P; r++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            write_row(r, lf[7:0] & ~lf[15:8], lf[10:8] ^ lf[2:0], lf[13:11]);
         end
         sweep("R2 R4 R5 generated program");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule